// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static RAM with flow-through reads and a shared, tristated data bus. Address and control inputs are captured on the rising clock edge. An access begins when either of two active-low address strobes is asserted while all three chip selects are active. The registered address then drives the memory array directly, so read data appears in the cycle after the edge, gated by an active-low output enable.

A 2-bit burst counter, cleared whenever a new address is loaded, produces the two lowest address bits. Each edge with the active-low advance input asserted steps it by one. A static strap picks the order of the four burst positions: when the strap is low the count is added to the start offset modulo 4, and when it is high the count is XORed with the start offset. Writes are masked per byte lane. Each lane is a 9-bit slice, 8 data bits plus one parity bit. An active-low global write stores every lane. An active-low lane-write enable, combined with one active-low select per lane, stores only the chosen lanes. An asynchronous sleep request passes through two clock stages. While the block is asleep it ignores every control, releases the bus and keeps its contents.

Top module: `sram_flow_burst`

## Requirements
- R1: On an edge where either strobe is low and `sel1_n`=0, `sel2`=1, `sel3_n`=0, the address is loaded. From the next edge on, with `out_en_n` low and no write registered, `dq` carries the word at that address.
- R2: On an edge where a strobe is low but any chip select is inactive, the access ends and `dq` is high impedance from that edge on.
- R3: With `ilv_order`=0, the k-th word of a burst (k = 0..3) sits at address bits [1:0] = (start + k) mod 4, with the upper bits unchanged.
- R4: With `ilv_order`=1, the k-th word of a burst sits at address bits [1:0] = start XOR k.
- R5: With no strobe, `adv_n`=0 steps the burst counter by one at the edge and `adv_n`=1 holds the current address.
- R6: `wr_all_n`=0 writes all four lanes of the current word, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R7: With `wr_all_n`=1 and `lane_wr_en_n`=0, each `lane_sel_n[i]`=0 stores `dq[9*i+8:9*i]`, and lanes whose select is 1 keep their old value.
- R8: With `wr_all_n`=1 and either `lane_wr_en_n`=1 or `lane_sel_n`=4'b1111, the cycle is a read and no stored data changes.
- R9: After an edge that performs a write, `dq` is high impedance for the next cycle even when `out_en_n` is low.
- R10: While `out_en_n` is high, `dq` is high impedance.
- R11: `sleep_req` takes effect on the second edge after it changes, in both directions. While asleep, `dq` is high impedance, every control is ignored and memory contents are kept.
- R12: During reset and after it, until an access is loaded, `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | 8 | Word address, captured when an access starts |
| strobe_p_n | input | 1 | First address strobe, active low |
| strobe_c_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enable for the per-lane selects, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low |
| ilv_order | input | 1 | Static strap: 0 linear, 1 interleaved burst order |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| dq | inout | 36 | Shared data bus, four 9-bit lanes |

## Verification
The assertions check, on every cycle, the burst counter's single step and its hold, the address capture on a start, the frozen state while asleep, and the bus release after a deselect or a write. Burst order under both strap values, lane masking against old data, the read-only cases of the write controls, data retention across sleep and reset, and the exact two-edge sleep latency only show up in the bench's scenarios. There, every cycle's bus value is compared with a reference computed from the requirements.

// File: rtl/sram_flow_burst_pkg.sv
`timescale 1ns/1ps
package sram_flow_burst_pkg;

   // Burst offset inside a 4-word group: XOR for interleaved, add for linear.
   function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       ilv);
      return ilv ? (start ^ cnt) : (start + cnt);
   endfunction

endpackage

// File: rtl/sram_flow_burst_sleep.sv
`timescale 1ns/1ps
module sram_flow_burst_sleep (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic asleep
);
   logic stage1_q, stage2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= 1'b0;
         stage2_q <= 1'b0;
      end else begin
         stage1_q <= req;
         stage2_q <= stage1_q;
      end
   end

   assign asleep = stage2_q;
endmodule

// File: rtl/sram_flow_burst_ctr.sv
`timescale 1ns/1ps
module sram_flow_burst_ctr
   import sram_flow_burst_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              load,
   input  logic              desel,
   input  logic              step,
   input  logic              ilv,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              active,
   output logic              nxt_active,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] nxt_addr
);
   localparam int HI_W = ADDR_W - 2;

   generate
      if (ADDR_W < 3) begin : g_bad_width
         $error("ADDR_W must be at least 3");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q, base_d;
   logic [1:0]        cnt_q, cnt_d;
   logic              act_q, act_d;

   always_comb begin
      base_d = base_q;
      cnt_d  = cnt_q;
      act_d  = act_q;
      if (!hold) begin
         if (load) begin
            base_d = addr_in;
            cnt_d  = 2'd0;
            act_d  = 1'b1;
         end else if (desel) begin
            act_d  = 1'b0;
         end else if (act_q && step) begin
            cnt_d  = cnt_q + 2'd1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else begin
         base_q <= base_d;
         cnt_q  <= cnt_d;
         act_q  <= act_d;
      end
   end

   assign active     = act_q;
   assign nxt_active = act_d;
   assign cur_addr   = {base_q[ADDR_W-1 -: HI_W], burst_lsb(base_q[1:0], cnt_q, ilv)};
   assign nxt_addr   = {base_d[ADDR_W-1 -: HI_W], burst_lsb(base_d[1:0], cnt_d, ilv)};

   AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !load && !desel && act_q && step) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R5
   AST_ADV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !load && !desel && !step) |=> $stable(cur_addr)); // R5
   AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && load) |=> (act_q && cur_addr == $past(addr_in))); // R1
   AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(cur_addr) && $stable(act_q))); // R11
endmodule

// File: rtl/sram_flow_burst_array.sv
`timescale 1ns/1ps
module sram_flow_burst_array #(
   parameter int ADDR_W = 8,
   parameter int NBYTES = 4,
   parameter int BYTE_W = 9
) (
   input  logic                     clk,
   input  logic [NBYTES-1:0]        we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [NBYTES*BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DEPTH * NBYTES > 4096) begin : g_too_big
         $error("array too large for this model");
      end
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         logic [BYTE_W-1:0] lane_mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we[g]) lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
         end
         assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/sram_flow_burst.sv
`timescale 1ns/1ps
module sram_flow_burst #(
   parameter int ADDR_W = 8,
   parameter int NBYTES = 4,
   parameter int BYTE_W = 9
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             addr,
   input  logic                          strobe_p_n,
   input  logic                          strobe_c_n,
   input  logic                          adv_n,
   input  logic                          sel1_n,
   input  logic                          sel2,
   input  logic                          sel3_n,
   input  logic                          wr_all_n,
   input  logic                          lane_wr_en_n,
   input  logic [NBYTES-1:0]             lane_sel_n,
   input  logic                          out_en_n,
   input  logic                          ilv_order,
   input  logic                          sleep_req,
   inout  wire logic [NBYTES*BYTE_W-1:0] dq
);
   localparam int DATA_W = NBYTES * BYTE_W;

   generate
      if (NBYTES < 1 || BYTE_W < 1) begin : g_bad_lane
         $error("NBYTES and BYTE_W must be positive");
      end
   endgenerate

   logic              asleep, chip_on, strobe, load, desel;
   logic              active, nxt_active, wr_q, dq_drive;
   logic [NBYTES-1:0] lane_mask, lane_we;
   logic [ADDR_W-1:0] cur_addr, nxt_addr;
   logic [DATA_W-1:0] rdata;

   assign chip_on = !sel1_n && sel2 && !sel3_n;
   assign strobe  = !strobe_p_n || !strobe_c_n;
   assign load    = strobe && chip_on;
   assign desel   = strobe && !chip_on;

   sram_flow_burst_sleep i_sleep (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (sleep_req),
      .asleep (asleep)
   );

   sram_flow_burst_ctr #(.ADDR_W(ADDR_W)) i_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (asleep),
      .load       (load),
      .desel      (desel),
      .step       (!adv_n),
      .ilv        (ilv_order),
      .addr_in    (addr),
      .active     (active),
      .nxt_active (nxt_active),
      .cur_addr   (cur_addr),
      .nxt_addr   (nxt_addr)
   );

   always_comb begin
      if (!wr_all_n)          lane_mask = '1;
      else if (!lane_wr_en_n) lane_mask = ~lane_sel_n;
      else                    lane_mask = '0;
   end

   assign lane_we = (!asleep && nxt_active) ? lane_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= |lane_we;
   end

   sram_flow_burst_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) i_array (
      .clk   (clk),
      .we    (lane_we),
      .waddr (nxt_addr),
      .wdata (dq),
      .raddr (cur_addr),
      .rdata (rdata)
   );

   assign dq_drive = active && !wr_q && !out_en_n && !asleep;
   assign dq       = dq_drive ? rdata : {DATA_W{1'bz}};

   AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && desel) |=> !dq_drive); // R2
   AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && nxt_active && (lane_mask != '0)) |=> !dq_drive); // R9
   AST_WE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> (lane_we == '0)); // R11
endmodule

// File: tb/test_sram_flow_burst.sv
`timescale 1ns/1ps
module test_sram_flow_burst;
   localparam int AW = 8;
   localparam int NB = 4;
   localparam int BW = 9;
   localparam int DW = NB * BW;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n, sp_n, sc_n, adv_n, c1_n, c2, c3_n, gw_n, bwe_n, oe_n, ilv, zz;
   logic [AW-1:0] addr;
   logic [NB-1:0] bw_n;
   logic          tb_en;
   logic [DW-1:0] tb_d;
   tri1  [DW-1:0] dq;
   assign dq = tb_en ? tb_d : {DW{1'bz}};

   sram_flow_burst i_sram_flow_burst (
      .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_p_n(sp_n), .strobe_c_n(sc_n),
      .adv_n(adv_n), .sel1_n(c1_n), .sel2(c2), .sel3_n(c3_n), .wr_all_n(gw_n),
      .lane_wr_en_n(bwe_n), .lane_sel_n(bw_n), .out_en_n(oe_n), .ilv_order(ilv),
      .sleep_req(zz), .dq(dq)
   );

   int checks = 0;
   int errs = 0;
   bit done = 0;

   // reference state
   logic [DW-1:0] m_mem [DEPTH];
   logic          m_act, m_wr, m_s1, m_s2;
   logic [AW-1:0] m_base;
   logic [1:0]    m_cnt;

   function automatic logic [AW-1:0] ref_addr(input logic [AW-1:0] b, input logic [1:0] c,
                                              input logic il);
      logic [1:0] lo;
      lo = il ? (b[1:0] ^ c) : (b[1:0] + c);
      return {b[AW-1:2], lo};
   endfunction

   function automatic logic [NB-1:0] ref_mask(input logic g, input logic e, input logic [NB-1:0] s);
      if (!g) return '1;
      if (!e) return ~s;
      return '0;
   endfunction

   task automatic model_edge();
      logic [NB-1:0] mk;
      logic          on, stb;
      if (!rst_n) begin
         m_act = 0; m_wr = 0; m_s1 = 0; m_s2 = 0; m_base = '0; m_cnt = '0;
         return;
      end
      m_wr = 0;
      if (!m_s2) begin
         on  = !c1_n && c2 && !c3_n;
         stb = !sp_n || !sc_n;
         if (stb && on) begin m_base = addr; m_cnt = 0; m_act = 1; end
         else if (stb) m_act = 0;
         else if (m_act && !adv_n) m_cnt = m_cnt + 2'd1;
         mk = ref_mask(gw_n, bwe_n, bw_n);
         if (m_act && mk != '0) begin
            for (int i = 0; i < NB; i++)
               if (mk[i]) m_mem[ref_addr(m_base, m_cnt, ilv)][i*BW +: BW] = tb_d[i*BW +: BW];
            m_wr = 1;
         end
      end
      m_s2 = m_s1;
      m_s1 = zz;
   endtask

   task automatic tick(input string tag);
      logic [DW-1:0] exp;
      @(posedge clk);
      model_edge();
      #0.5 tb_en = 0;
      #0.5;
      exp = (m_act && !m_wr && !oe_n && !m_s2) ? m_mem[ref_addr(m_base, m_cnt, ilv)] : '1;
      checks++;
      if (dq !== exp) begin
         errs++;
         $display("FAIL %s: dq=%h expected %h", tag, dq, exp);
      end
      @(negedge clk);
   endtask

   task automatic idle();
      sp_n = 1; sc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
      c1_n = 0; c2 = 1; c3_n = 0; oe_n = 0; tb_en = 0;
   endtask

   function automatic logic [DW-1:0] rnd_word();
      logic [DW-1:0] w;
      w = {$urandom, $urandom};
      w[0] = 1'b0;
      return w;
   endfunction

   task automatic do_reset(input logic strap);
      rst_n = 0; ilv = strap; idle();
      tick("R12 reset");
      tick("R12 reset");
      rst_n = 1;
      tick("R12 after reset");
   endtask

   task automatic random_phase(input int n);
      int sel;
      for (int k = 0; k < n; k++) begin
         idle();
         if (zz) zz = ($urandom % 8) != 0;
         else    zz = ($urandom % 100) == 0;
         sel = $urandom % 8;
         if (sel == 0) sp_n = 0;
         if (sel == 1) sc_n = 0;
         if (sel == 2) begin sp_n = 0; sc_n = 0; end
         addr = AW'($urandom);
         if ($urandom % 8 == 0) begin
            sel = $urandom % 3;
            if (sel == 0) c1_n = 1; else if (sel == 1) c2 = 0; else c3_n = 1;
         end
         adv_n = 1'($urandom);
         if ($urandom % 3 == 0) begin
            oe_n = 1; tb_en = 1; tb_d = rnd_word();
            gw_n = 1'($urandom); bwe_n = 1'($urandom); bw_n = NB'($urandom);
         end else begin
            bwe_n = 1'($urandom);
            bw_n  = bwe_n ? NB'($urandom) : '1;
            oe_n  = ($urandom % 4) == 0;
         end
         tick("R1 random");
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      zz = 0; addr = '0; tb_d = '0;
      @(negedge clk);
      do_reset(1'b0);

      // fill the whole array with global-write bursts
      for (int a = 0; a < DEPTH / 4; a++) begin
         idle(); sc_n = 0; addr = AW'(a * 4); gw_n = 0; oe_n = 1; tb_en = 1; tb_d = rnd_word();
         tick("R6 fill");
         for (int j = 0; j < 3; j++) begin
            idle(); adv_n = 0; gw_n = 0; oe_n = 1; tb_en = 1; tb_d = rnd_word();
            tick("R6 fill burst");
         end
      end

      // linear burst from offset 1: 0x21,0x22,0x23,0x20
      idle(); sp_n = 0; addr = 8'h21; tick("R1 load read");
      for (int j = 0; j < 3; j++) begin idle(); adv_n = 0; tick("R3 linear"); end
      idle(); tick("R5 hold"); idle(); tick("R5 hold");
      idle(); oe_n = 1; tick("R10 oe high");
      idle(); sp_n = 0; c2 = 0; tick("R2 deselect sel2");
      idle(); sc_n = 0; c1_n = 1; tick("R2 deselect sel1");

      // lane write on lane 1 only
      idle(); sc_n = 0; addr = 8'h40; bwe_n = 0; bw_n = 4'b1101; oe_n = 1; tb_en = 1;
      tb_d = rnd_word(); tick("R7 lane write");
      idle(); sc_n = 0; addr = 8'h40; tick("R7 readback");
      // enable low but no lane chosen: read
      idle(); sc_n = 0; addr = 8'h41; bwe_n = 0; bw_n = 4'hf; oe_n = 1; tb_en = 1;
      tb_d = 36'h0; tick("R8 no lane");
      idle(); tick("R8 readback");
      // global write overrides lane controls
      idle(); sc_n = 0; addr = 8'h42; gw_n = 0; bwe_n = 1; bw_n = 4'hf; oe_n = 1; tb_en = 1;
      tb_d = rnd_word(); tick("R6 global");
      idle(); tick("R6 readback");
      // back-to-back writes with output enable low on the second
      idle(); sc_n = 0; addr = 8'h50; gw_n = 0; oe_n = 1; tb_en = 1; tb_d = rnd_word();
      tick("R9 first write");
      idle(); adv_n = 0; gw_n = 0; oe_n = 0; tb_en = 1; tb_d = rnd_word();
      tick("R9 bus released");
      idle(); tick("R9 readback");

      // interleaved burst from offset 1: 0x21,0x20,0x23,0x22
      do_reset(1'b1);
      idle(); sp_n = 0; addr = 8'h21; tick("R4 load");
      for (int j = 0; j < 3; j++) begin idle(); adv_n = 0; tick("R4 interleaved"); end

      // sleep entry, ignored write, exit
      idle(); sp_n = 0; addr = 8'h21; tick("R11 before sleep");
      zz = 1; idle(); tick("R11 entry edge 1");
      idle(); tick("R11 entry edge 2");
      idle(); sc_n = 0; addr = 8'h21; gw_n = 0; oe_n = 1; tb_en = 1; tb_d = 36'h0;
      tick("R11 write ignored");
      zz = 0; idle(); adv_n = 0; tick("R11 exit edge 1");
      idle(); tick("R11 exit edge 2");
      idle(); tick("R11 data kept");

      do_reset(1'b0);
      random_phase(1500);
      do_reset(1'b1);
      random_phase(1500);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errs);
         $finish;
      end
   end
endmodule